// File: doc/BRIEF.md
# Branch Prediction Confidence Rater

This block tells a speculative front end how much to trust each branch prediction. It keeps a table of per-branch run-length counters. Each counter counts the correct predictions seen since that branch was last mispredicted. When a prediction is looked up, the counter selected by the branch address is compared with a threshold that software can change, and the block returns one confidence bit. When a branch resolves, the update port reports whether the prediction was right. The counter then grows by one and stops at its maximum on a correct prediction, or drops to zero on a miss. A branch that flips direction often and without pattern therefore never builds up a long run and stays at low confidence.

A mode pin changes the source of the confidence. In this mode the block ignores the table and rates a prediction as high confidence only when the predictor's own two-bit saturating counter, supplied with the lookup, sits in one of its two strong states. Every resolved prediction is also tallied into one of four saturating statistics counters. The four classes are correct with high confidence, correct with low confidence, wrong with high confidence and wrong with low confidence. A synchronous clear input resets all four tallies.

Lookups use a valid/ready request channel and a valid/ready response channel. A request is accepted in any cycle where `lk_valid` and `lk_ready` are both high, and `lk_ready` is high whenever the response register is empty or is being drained in the same cycle. A response that has not been taken holds its value until `resp_ready` goes high. The update channel never applies back-pressure, so `upd_ready` is always high.

Top module: `brconf_est`

## Requirements
- R1: After reset all table counters, all four statistics counters and `resp_valid` are zero, and `lk_ready` is high.
- R2: With `sat_mode` low, `resp_conf` is 1 exactly when the selected table counter is strictly greater than `thresh`. A counter equal to or below `thresh` gives 0.
- R3: An update with `upd_correct`=1 increments the selected counter by one. The counter saturates at 2^CNT_W-1.
- R4: An update with `upd_correct`=0 clears the selected counter to zero.
- R5: The table entry is chosen by the low IDX_W bits of the address. Addresses that differ only above those bits share one entry.
- R6: The response for an accepted lookup appears with `resp_valid`=1 at the first clock edge after acceptance. While `resp_ready` is low, `resp_valid` stays 1, `resp_conf` stays stable and `lk_ready` is 0.
- R7: A lookup accepted in the same cycle as an update to the same entry sees the counter value that the update writes.
- R8: With `sat_mode` high, `resp_conf` is 1 exactly when `lk_pred_ctr` is 2'b00 or 2'b11, whatever the table holds.
- R9: Each update increments exactly one statistics counter: `stat_chc` (correct, `upd_conf`=1), `stat_clc` (correct, `upd_conf`=0), `stat_ihc` (wrong, `upd_conf`=1) or `stat_ilc` (wrong, `upd_conf`=0). The new value is visible one cycle after the update.
- R10: Each statistics counter saturates at 2^STAT_W-1.
- R11: `stat_clr` high zeroes all four statistics counters at the next edge. It takes priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sat_mode | input | 1 | 1: confidence from the predictor's two-bit counter |
| thresh | input | CNT_W | Confidence threshold |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | ADDR_W | Branch address of the lookup |
| lk_pred_ctr | input | 2 | Predictor two-bit counter state for the lookup |
| resp_valid | output | 1 | Confidence response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_conf | output | 1 | 1 = high confidence |
| upd_valid | input | 1 | Resolved-prediction update valid |
| upd_ready | output | 1 | Always 1 |
| upd_addr | input | ADDR_W | Branch address of the resolved prediction |
| upd_correct | input | 1 | 1 = prediction was correct |
| upd_conf | input | 1 | Confidence that was given to this prediction |
| stat_clr | input | 1 | Synchronous clear of the statistics counters |
| stat_chc | output | STAT_W | Correct, high confidence tally |
| stat_clc | output | STAT_W | Correct, low confidence tally |
| stat_ihc | output | STAT_W | Wrong, high confidence tally |
| stat_ilc | output | STAT_W | Wrong, low confidence tally |

## Verification
A lookup result is due one edge after acceptance. The bench drives every request on a falling edge and samples the response at the next falling edge, after exactly one rising edge. Table updates and statistics updates also take one edge, so counter values and tallies are checked at the falling edge after the update is driven. A same-cycle update is checked against the response of the lookup driven with it. Under back-pressure the held response is sampled over several falling edges and must not change. The sweep covers every threshold against every counter value in a three-bit configuration, and the expected value is computed arithmetically from a bench-side model.

// File: rtl/brconf_pkg.sv
package brconf_pkg;
  typedef enum logic [1:0] {
    CLS_CHC = 2'd0,
    CLS_CLC = 2'd1,
    CLS_IHC = 2'd2,
    CLS_ILC = 2'd3
  } conf_class_e;

  function automatic conf_class_e classify(input logic correct, input logic conf);
    return conf_class_e'({~correct, ~conf});
  endfunction

  function automatic logic strong_state(input logic [1:0] ctr);
    return (ctr == 2'b00) || (ctr == 2'b11);
  endfunction
endpackage

// File: rtl/mdc_table.sv
module mdc_table #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_correct,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] upd_next;

  assign cur = mem[upd_idx];

  always_comb begin
    if (!upd_correct)      upd_next = '0;
    else if (cur == MAXV)  upd_next = MAXV;
    else                   upd_next = cur + CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (upd_en && upd_idx == IDX_W'(g))     mem[g] <= upd_next;
    end
  end

  assign rd_cnt = (upd_en && upd_idx == rd_idx) ? upd_next : mem[rd_idx];

  AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_correct) |=> (mem[$past(upd_idx)] == '0)); // R4

  AST_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_correct && cur != MAXV) |=> (mem[$past(upd_idx)] == $past(cur) + CNT_W'(1))); // R3

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_correct && cur == MAXV) |=> (mem[$past(upd_idx)] == MAXV)); // R3
endmodule

// File: rtl/conf_stats.sv
module conf_stats
  import brconf_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   inc_en,
  input  logic                   correct,
  input  logic                   conf,
  output logic [3:0][STAT_W-1:0] cnt_o
);
  localparam logic [STAT_W-1:0] SMAX = {STAT_W{1'b1}};

  conf_class_e cls;
  assign cls = classify(correct, conf);

  for (genvar g = 0; g < 4; g++) begin : g_cls
    logic hit;
    assign hit = inc_en && (cls == conf_class_e'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_o[g] <= '0;
      else if (clr)                   cnt_o[g] <= '0;
      else if (hit && cnt_o[g] != SMAX) cnt_o[g] <= cnt_o[g] + STAT_W'(1);
    end

    AST_STAT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && cnt_o[g] == SMAX) |=> (cnt_o[g] == SMAX)); // R10
  end

  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_o == '0)); // R11

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones({cnt_o[0] != $past(cnt_o[0]), cnt_o[1] != $past(cnt_o[1]),
                          cnt_o[2] != $past(cnt_o[2]), cnt_o[3] != $past(cnt_o[3])}) <= 1)); // R9
endmodule

// File: rtl/brconf_est.sv
module brconf_est
  import brconf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 4,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_mode,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_pred_ctr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_conf,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_correct,
  input  logic              upd_conf,
  input  logic              stat_clr,
  output logic [STAT_W-1:0] stat_chc,
  output logic [STAT_W-1:0] stat_clc,
  output logic [STAT_W-1:0] stat_ihc,
  output logic [STAT_W-1:0] stat_ilc
);
  logic [CNT_W-1:0]       rd_cnt;
  logic                   lk_fire;
  logic                   conf_now;
  logic [3:0][STAT_W-1:0] tallies;

  assign upd_ready = 1'b1;
  assign lk_ready  = !resp_valid || resp_ready;
  assign lk_fire   = lk_valid && lk_ready;

  mdc_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_valid),
    .upd_idx    (upd_addr[IDX_W-1:0]),
    .upd_correct(upd_correct),
    .rd_idx     (lk_addr[IDX_W-1:0]),
    .rd_cnt     (rd_cnt)
  );

  assign conf_now = sat_mode ? strong_state(lk_pred_ctr) : (rd_cnt > thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_conf  <= 1'b0;
    end else if (lk_fire) begin
      resp_valid <= 1'b1;
      resp_conf  <= conf_now;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  conf_stats #(.STAT_W(STAT_W)) u_stats (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stat_clr),
    .inc_en(upd_valid),
    .correct(upd_correct),
    .conf  (upd_conf),
    .cnt_o (tallies)
  );

  assign stat_chc = tallies[CLS_CHC];
  assign stat_clc = tallies[CLS_CLC];
  assign stat_ihc = tallies[CLS_IHC];
  assign stat_ilc = tallies[CLS_ILC];

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_conf))); // R6

  AST_RESP_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> resp_valid); // R6

  AST_STRONG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && sat_mode) |=> (resp_conf == ($past(lk_pred_ctr) == 2'b00 || $past(lk_pred_ctr) == 2'b11))); // R8
endmodule

// File: tb/brconf_est_bench.sv
module brconf_est_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int IW = 2;
  localparam int CW = 3;
  localparam int SW = 4;
  localparam int CMAX = (1 << CW) - 1;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sat_mode = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic lk_valid = 1'b0;
  logic lk_ready;
  logic [AW-1:0] lk_addr = '0;
  logic [1:0] lk_pred_ctr = '0;
  logic resp_valid;
  logic resp_ready = 1'b1;
  logic resp_conf;
  logic upd_valid = 1'b0;
  logic upd_ready;
  logic [AW-1:0] upd_addr = '0;
  logic upd_correct = 1'b0;
  logic upd_conf = 1'b0;
  logic stat_clr = 1'b0;
  logic [SW-1:0] stat_chc, stat_clc, stat_ihc, stat_ilc;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int m [1 << IW];
  int s [4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  brconf_est #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(CW), .STAT_W(SW)) u_brconf_est (
    .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .thresh(thresh),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_pred_ctr(lk_pred_ctr),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_conf(resp_conf),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_addr(upd_addr),
    .upd_correct(upd_correct), .upd_conf(upd_conf), .stat_clr(stat_clr),
    .stat_chc(stat_chc), .stat_clc(stat_clc), .stat_ihc(stat_ihc), .stat_ilc(stat_ilc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [AW-1:0] a);
    return int'(a[IW-1:0]);
  endfunction

  task automatic model_upd(input logic [AW-1:0] a, input bit c, input bit cf, input bit clr);
    int k;
    if (c) m[idx_of(a)] = (m[idx_of(a)] == CMAX) ? CMAX : m[idx_of(a)] + 1;
    else   m[idx_of(a)] = 0;
    k = (c ? 0 : 2) + (cf ? 0 : 1);
    if (clr) for (int i = 0; i < 4; i++) s[i] = 0;
    else if (s[k] < SMAX) s[k]++;
  endtask

  task automatic upd(input logic [AW-1:0] a, input bit c, input bit cf);
    @(negedge clk);
    upd_valid = 1; upd_addr = a; upd_correct = c; upd_conf = cf;
    @(negedge clk);
    upd_valid = 0;
    model_upd(a, c, cf, 0);
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [1:0] p, input bit exp, input string req);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_pred_ctr = p;
    @(negedge clk);
    lk_valid = 0;
    chk(resp_valid == 1'b1, req, int'(resp_valid), 1);
    chk(resp_conf == exp, req, int'(resp_conf), int'(exp));
  endtask

  task automatic clear_stats();
    @(negedge clk);
    stat_clr = 1;
    @(negedge clk);
    stat_clr = 0;
    for (int i = 0; i < 4; i++) s[i] = 0;
  endtask

  task automatic check_stats(input string req);
    chk(int'(stat_chc) == s[0], req, int'(stat_chc), s[0]);
    chk(int'(stat_clc) == s[1], req, int'(stat_clc), s[1]);
    chk(int'(stat_ihc) == s[2], req, int'(stat_ihc), s[2]);
    chk(int'(stat_ilc) == s[3], req, int'(stat_ilc), s[3]);
  endtask

  task automatic set_entry(input logic [AW-1:0] a, input int v);
    upd(a, 0, 0);
    for (int i = 0; i < v; i++) upd(a, 1, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << IW); i++) m[i] = 0;
    for (int i = 0; i < 4; i++) s[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(resp_valid == 1'b0, "R1", int'(resp_valid), 0);
    chk(lk_ready == 1'b1, "R1", int'(lk_ready), 1);
    check_stats("R1");
    for (int e = 0; e < (1 << IW); e++) look(AW'(e), 2'b01, 1'b0, "R1");

    // R2: every threshold against every counter value
    for (int th = 0; th <= CMAX; th++) begin
      thresh = CW'(th);
      for (int c = 0; c <= CMAX; c++) begin
        set_entry(AW'(c % 4), c);
        look(AW'(c % 4), 2'b01, c > th, "R2");
      end
    end

    // R3: run length saturates at CMAX
    set_entry(AW'(2), CMAX + 3);
    thresh = CW'(CMAX - 1);
    look(AW'(2), 2'b01, 1'b1, "R3");
    thresh = CW'(CMAX);
    look(AW'(2), 2'b01, 1'b0, "R3");

    // R4: a single miss drops confidence
    thresh = '0;
    upd(AW'(2), 0, 1);
    look(AW'(2), 2'b01, 1'b0, "R4");
    // alternating outcomes never rise above threshold 1
    thresh = CW'(1);
    for (int i = 0; i < 6; i++) begin
      upd(AW'(2), i[0], 0);
      look(AW'(2), 2'b01, 1'b0, "R4");
    end

    // R5: upper address bits alias onto one entry
    thresh = CW'(2);
    set_entry(AW'(12'h105), 3);
    look(AW'(12'h001), 2'b01, 1'b1, "R5");
    look(AW'(12'hF01), 2'b01, 1'b1, "R5");
    upd(AW'(12'h7F9), 0, 0);
    look(AW'(12'h101), 2'b01, 1'b0, "R5");

    // R7: same-cycle update is seen by the lookup
    thresh = '0;
    set_entry(AW'(1), CMAX);
    @(negedge clk);
    upd_valid = 1; upd_addr = AW'(1); upd_correct = 0; upd_conf = 1;
    lk_valid = 1; lk_addr = AW'(1);
    @(negedge clk);
    upd_valid = 0; lk_valid = 0;
    model_upd(AW'(1), 0, 1, 0);
    chk(resp_conf == 1'b0, "R7", int'(resp_conf), 0);
    set_entry(AW'(3), 0);
    @(negedge clk);
    upd_valid = 1; upd_addr = AW'(3); upd_correct = 1; upd_conf = 0;
    lk_valid = 1; lk_addr = AW'(3);
    @(negedge clk);
    upd_valid = 0; lk_valid = 0;
    model_upd(AW'(3), 1, 0, 0);
    chk(resp_conf == 1'b1, "R7", int'(resp_conf), 1);

    // R8: strong-state mode ignores the table
    set_entry(AW'(0), CMAX);
    thresh = '0;
    sat_mode = 1;
    for (int p = 0; p < 4; p++) look(AW'(0), 2'(p), (p == 0 || p == 3), "R8");
    set_entry(AW'(0), 0);
    look(AW'(0), 2'b11, 1'b1, "R8");
    sat_mode = 0;

    // R6: back-pressure holds the response
    set_entry(AW'(2), CMAX);
    @(negedge clk);
    resp_ready = 0;
    lk_valid = 1; lk_addr = AW'(2);
    @(negedge clk);
    lk_addr = AW'(0);
    chk(resp_valid == 1'b1, "R6", int'(resp_valid), 1);
    chk(resp_conf == 1'b1, "R6", int'(resp_conf), 1);
    for (int i = 0; i < 3; i++) begin
      chk(lk_ready == 1'b0, "R6", int'(lk_ready), 0);
      @(negedge clk);
      chk(resp_valid == 1'b1 && resp_conf == 1'b1, "R6", int'(resp_conf), 1);
    end
    lk_valid = 0;
    resp_ready = 1;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R6", int'(resp_valid), 0);

    // R9: one tally per update, by class
    clear_stats();
    check_stats("R11");
    for (int i = 0; i < 3; i++) upd(AW'(i), 1, 1);
    for (int i = 0; i < 2; i++) upd(AW'(i), 1, 0);
    upd(AW'(3), 0, 1);
    for (int i = 0; i < 4; i++) upd(AW'(i), 0, 0);
    check_stats("R9");

    // R10: tallies saturate
    for (int i = 0; i < SMAX + 4; i++) upd(AW'(1), 1, 1);
    chk(int'(stat_chc) == SMAX, "R10", int'(stat_chc), SMAX);
    check_stats("R10");

    // R11: clear wins over a same-cycle update
    @(negedge clk);
    stat_clr = 1; upd_valid = 1; upd_addr = AW'(0); upd_correct = 0; upd_conf = 0;
    @(negedge clk);
    stat_clr = 0; upd_valid = 0;
    model_upd(AW'(0), 0, 0, 1);
    check_stats("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule